// File: doc/BRIEF.md
# Debug Access Test-Port Target

This block is the target end of a serial test port. It is used to reach memory and processor registers for debug. A host drives the test clock, the mode select line and serial data in, and reads serial data out. A sixteen-state test-port controller decodes the mode line. A 4-bit instruction register picks one of four debug data registers or a one-bit bypass path. The four registers are a read-only status word, a 4-bit command, a 32-bit address and a 32-bit data word.

A host loads a command, an address and, for writes, a data word. It then steers the controller from Update-DR or Update-IR into Run-Test/Idle. On the first test-clock edge spent in Run-Test/Idle, a bus engine issues one request on a request/acknowledge master port. The request is a memory word, core register or auxiliary register access, read or write. When the access completes, read data lands in the data register and the address register steps forward. This lets a block of words be moved without reloading the address. The host polls the status register to learn whether the access is stalled, failed or ready.

The controller states are Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR-Scan, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. Their transitions on the mode line follow the standard test-port table. The bus engine has two states. ENG_IDLE moves to ENG_WAIT on an armed start with a valid command. ENG_WAIT moves back to ENG_IDLE on acknowledge.

Top module: `dbg_tap_target`

## Requirements
- R1: The controller follows the standard sixteen-state test-port transition table on each rising test-clock edge. Five or more edges with the mode line high reach Test-Logic-Reset from any state.
- R2: While in Test-Logic-Reset (and on rst_n low), the registers are set to their defaults: instruction 0xF, command 0x3, address 0, data 0, ready 0, failed 0.
- R3: The instruction register is 4 bits and shifts LSB first. Capture-IR loads 4'b0001. Code 0x8 selects status (4 bits), 0x9 the command (4 bits), 0xA the address (32 bits) and 0xB the data (32 bits). Any other code selects a 1-bit bypass register that captures 0.
- R4: Data registers shift LSB first from tdi toward tdo. tdo shows bit 0 of the shift register during Shift-DR and Shift-IR and is 0 otherwise. Bus word bit 0 is the first bit on the chain.
- R5: Capture-DR on status loads bit0 = stalled (access in flight), bit1 = failed, bit2 = ready, bit3 = 0. Update-DR with status selected changes no register.
- R6: Command bit 2 set means read, bits [1:0] give the kind (0 memory, 1 core register, 2 auxiliary register). A valid command is 0x0-0x2 or 0x4-0x6. Entering Run-Test/Idle from Update-DR or Update-IR arms a start. The next edge, if no access is in flight, raises bus_req with the kind, write flag, address and data that were loaded.
- R7: Commands 0x3 and 0x7-0xF are no-ops. A start with them issues no request and sets ready.
- R8: bus_req and its fields hold stable until bus_ack. A start attempted while an access is in flight is ignored.
- R9: On acknowledge, bus_err sets failed and leaves address and data alone. Otherwise ready is set, read data is written into the data register, and the address grows by 4 for memory or 1 for a register kind.
- R10: Starting an access clears ready and failed. While it is in flight, neither is set.
- R11: When an acknowledge falls on the Update-DR edge that writes the address or data register, the scanned value wins over the increment or the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_req | output | 1 | Access request, held until acknowledge |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_kind | output | 2 | 0 memory word, 1 core register, 2 auxiliary register |
| bus_addr | output | 32 | Access address or register number |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with bus_ack |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The collision of interest is the bus engine completing an access on the same edge that an Update-DR writes the address register. At that edge the increment and the scanned value both target the same flops. The bench holds the acknowledge back and releases it only in the cycle the controller sits in Update-DR with the address selected. A later address read must then return the scanned value and not the incremented one. A behavioural model stepped every clock predicts tdo and every bus field throughout, including a start attempted while busy.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_t;

    localparam int IR_W   = 4;
    localparam int CMD_W  = 4;
    localparam int STAT_W = 4;

    localparam logic [IR_W-1:0]  IR_STATUS = 4'h8;
    localparam logic [IR_W-1:0]  IR_CMD    = 4'h9;
    localparam logic [IR_W-1:0]  IR_ADDR   = 4'hA;
    localparam logic [IR_W-1:0]  IR_DATA   = 4'hB;
    localparam logic [IR_W-1:0]  IR_DEF    = 4'hF;
    localparam logic [CMD_W-1:0] CMD_NOP   = 4'h3;

endpackage

// File: rtl/dtt_tap_fsm.sv
module dtt_tap_fsm
    import dtt_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state_q,
    output logic       idle_entry
);

    tap_state_t state_d;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= TS_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            default:   state_d = TS_RESET;
        endcase
    end

    // entering Run-Test/Idle from an update state arms a bus start
    always_comb begin
        idle_entry = ((state_q == TS_UPD_DR) || (state_q == TS_UPD_IR)) && !tms;
    end

    // R1: five consecutive high mode samples land in Test-Logic-Reset
    p_five_ones_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == TS_RESET));

endmodule

// File: rtl/dtt_bus_engine.sv
module dtt_bus_engine
    import dtt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              in_reset,
    input  logic              idle_entry,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              ready_q,
    output logic              failed_q,
    output logic              cpl_ok,
    output logic              cpl_read,
    output logic              cpl_mem
);

    eng_state_t st_q;
    logic       arm_q;
    logic       op_valid;
    logic       go;
    logic       cpl;

    always_comb begin
        op_valid = !cmd_q[3] && (cmd_q[1:0] != 2'b11);
        go       = (st_q == ENG_IDLE) && arm_q;
        cpl      = (st_q == ENG_WAIT) && bus_ack;
        cpl_ok   = cpl && !bus_err;
        cpl_read = !bus_we;
        cpl_mem  = (bus_kind == 2'd0);
        bus_req  = (st_q == ENG_WAIT);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ENG_IDLE;
        end else begin
            unique case (st_q)
                ENG_IDLE: if (go && op_valid) st_q <= ENG_WAIT;
                ENG_WAIT: if (bus_ack)        st_q <= ENG_IDLE;
                default:  st_q <= ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            bus_we    <= 1'b0;
            bus_kind  <= 2'd0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            ready_q   <= 1'b0;
            failed_q  <= 1'b0;
        end else begin
            arm_q <= idle_entry;
            if (go && op_valid) begin
                bus_we    <= !cmd_q[2];
                bus_kind  <= cmd_q[1:0];
                bus_addr  <= addr_q;
                bus_wdata <= data_q;
                ready_q   <= 1'b0;
                failed_q  <= 1'b0;
            end else if (go) begin
                ready_q   <= 1'b1;
                failed_q  <= 1'b0;
            end else if (cpl) begin
                ready_q   <= !bus_err;
                failed_q  <= bus_err;
            end
            if (in_reset) begin
                ready_q  <= 1'b0;
                failed_q <= 1'b0;
            end
        end
    end

    // R8: an outstanding request and its fields hold until acknowledged
    p_req_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_kind) && $stable(bus_we)));

    // R10: an access in flight shows neither ready nor failed
    p_busy_clear_r10: assert property (@(posedge tck) disable iff (!rst_n)
        bus_req |-> !(ready_q || failed_q));

    // R9: ready and failed are never both set
    p_flags_excl_r9: assert property (@(posedge tck) disable iff (!rst_n)
        !(ready_q && failed_q));

endmodule

// File: rtl/dtt_scan_chain.sv
module dtt_scan_chain
    import dtt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MEM_STEP = 4,
    parameter int REG_STEP = 1
) (
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_t        state_q,
    input  logic              tdi,
    output logic              tdo,
    input  logic              busy,
    input  logic              ready_q,
    input  logic              failed_q,
    input  logic              cpl_ok,
    input  logic              cpl_read,
    input  logic              cpl_mem,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int SR_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam logic [ADDR_W-1:0] MEM_INC = ADDR_W'(MEM_STEP);
    localparam logic [ADDR_W-1:0] REG_INC = ADDR_W'(REG_STEP);

    logic [IR_W-1:0] ir_q;
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] dr_shift;
    logic [SR_W-1:0] dr_cap;
    logic [SR_W-1:0] ir_shift;
    int              dr_len;
    logic            upd_addr;
    logic            upd_data;

    always_comb begin
        unique case (ir_q)
            IR_STATUS: dr_len = STAT_W;
            IR_CMD:    dr_len = CMD_W;
            IR_ADDR:   dr_len = ADDR_W;
            IR_DATA:   dr_len = DATA_W;
            default:   dr_len = 1;
        endcase
    end

    always_comb begin
        unique case (ir_q)
            IR_STATUS: dr_cap = SR_W'({1'b0, ready_q, failed_q, busy});
            IR_CMD:    dr_cap = SR_W'(cmd_q);
            IR_ADDR:   dr_cap = SR_W'(addr_q);
            IR_DATA:   dr_cap = SR_W'(data_q);
            default:   dr_cap = '0;
        endcase
    end

    always_comb begin
        dr_shift = {1'b0, sr_q[SR_W-1:1]};
        dr_shift[dr_len-1] = tdi;
        ir_shift = '0;
        ir_shift[IR_W-1:0] = {tdi, sr_q[IR_W-1:1]};
    end

    always_comb begin
        upd_addr = (state_q == TS_UPD_DR) && (ir_q == IR_ADDR);
        upd_data = (state_q == TS_UPD_DR) && (ir_q == IR_DATA);
        tdo      = ((state_q == TS_SH_DR) || (state_q == TS_SH_IR)) ? sr_q[0] : 1'b0;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            unique case (state_q)
                TS_CAP_IR: sr_q <= SR_W'(1);
                TS_SH_IR:  sr_q <= ir_shift;
                TS_CAP_DR: sr_q <= dr_cap;
                TS_SH_DR:  sr_q <= dr_shift;
                default:   sr_q <= sr_q;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_q   <= IR_DEF;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == TS_RESET) begin
            ir_q   <= IR_DEF;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == TS_UPD_IR) ir_q <= sr_q[IR_W-1:0];
            if ((state_q == TS_UPD_DR) && (ir_q == IR_CMD)) cmd_q <= sr_q[CMD_W-1:0];
            if (upd_addr)                addr_q <= sr_q[ADDR_W-1:0];
            else if (cpl_ok)             addr_q <= addr_q + (cpl_mem ? MEM_INC : REG_INC);
            if (upd_data)                data_q <= sr_q[DATA_W-1:0];
            else if (cpl_ok && cpl_read) data_q <= bus_rdata;
        end
    end

    // R9: a clean completion steps the address by the kind-dependent amount
    p_addr_step_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (cpl_ok && (state_q != TS_RESET) && !upd_addr)
        |=> (addr_q == $past(addr_q) + ($past(cpl_mem) ? MEM_INC : REG_INC)));

    // R5: an update of the status selection alters no register
    p_status_ro_r5: assert property (@(posedge tck) disable iff (!rst_n)
        ((state_q == TS_UPD_DR) && (ir_q == IR_STATUS) && !cpl_ok)
        |=> ($stable(cmd_q) && $stable(addr_q) && $stable(data_q)));

endmodule

// File: rtl/dbg_tap_target.sv
module dbg_tap_target
    import dtt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MEM_STEP = 4,
    parameter int REG_STEP = 1
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);

    tap_state_t        state_q;
    logic              idle_entry;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ready_q;
    logic              failed_q;
    logic              cpl_ok;
    logic              cpl_read;
    logic              cpl_mem;
    logic              in_reset;

    assign in_reset = (state_q == TS_RESET);

    dtt_tap_fsm u_fsm (
        .tck        (tck),
        .rst_n      (rst_n),
        .tms        (tms),
        .state_q    (state_q),
        .idle_entry (idle_entry)
    );

    dtt_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .tck        (tck),
        .rst_n      (rst_n),
        .in_reset   (in_reset),
        .idle_entry (idle_entry),
        .cmd_q      (cmd_q),
        .addr_q     (addr_q),
        .data_q     (data_q),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_kind   (bus_kind),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .ready_q    (ready_q),
        .failed_q   (failed_q),
        .cpl_ok     (cpl_ok),
        .cpl_read   (cpl_read),
        .cpl_mem    (cpl_mem)
    );

    dtt_scan_chain #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_STEP(MEM_STEP), .REG_STEP(REG_STEP)
    ) u_chain (
        .tck       (tck),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .tdi       (tdi),
        .tdo       (tdo),
        .busy      (bus_req),
        .ready_q   (ready_q),
        .failed_q  (failed_q),
        .cpl_ok    (cpl_ok),
        .cpl_read  (cpl_read),
        .cpl_mem   (cpl_mem),
        .bus_rdata (bus_rdata),
        .cmd_q     (cmd_q),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

endmodule

// File: tb/dbg_tap_target_bench.sv
module dbg_tap_target_bench;

    localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                   S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                   S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;
    localparam logic [31:0] ERR_ADDR = 32'hDEAD_0000;
    localparam logic [31:0] RD_MASK  = 32'h5A5A_1234;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        bus_req, bus_we;
    logic [1:0]  bus_kind;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #4 tck = ~tck;

    dbg_tap_target u_dbg_tap_target (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .bus_req(bus_req), .bus_we(bus_we), .bus_kind(bus_kind),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model
    int          m_st = S_TLR;
    logic [31:0] m_sr = '0;
    logic [3:0]  m_ir = 4'hF, m_cmd = 4'h3;
    logic [31:0] m_addr = '0, m_data = '0;
    bit          m_busy = 0, m_ready = 0, m_failed = 0, m_arm = 0;
    logic [31:0] m_baddr = '0, m_bwdata = '0;
    logic [1:0]  m_bkind = '0;
    bit          m_bwe = 0;
    int          m_wait = 0;
    int          ack_lat = 2;
    bit          force_ack = 0;
    logic        last_tdo;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nxt(int s, bit t);
        case (s)
            S_TLR:  return t ? S_TLR  : S_RTI;
            S_RTI:  return t ? S_SDR  : S_RTI;
            S_SDR:  return t ? S_SIR  : S_CDR;
            S_CDR:  return t ? S_E1DR : S_SHDR;
            S_SHDR: return t ? S_E1DR : S_SHDR;
            S_E1DR: return t ? S_UDR  : S_PDR;
            S_PDR:  return t ? S_E2DR : S_PDR;
            S_E2DR: return t ? S_UDR  : S_SHDR;
            S_UDR:  return t ? S_SDR  : S_RTI;
            S_SIR:  return t ? S_TLR  : S_CIR;
            S_CIR:  return t ? S_E1IR : S_SHIR;
            S_SHIR: return t ? S_E1IR : S_SHIR;
            S_E1IR: return t ? S_UIR  : S_PIR;
            S_PIR:  return t ? S_E2IR : S_PIR;
            S_E2IR: return t ? S_UIR  : S_SHIR;
            default: return t ? S_SDR : S_RTI;
        endcase
    endfunction

    function automatic int len_of(logic [3:0] code);
        case (code)
            4'h8, 4'h9: return 4;
            4'hA, 4'hB: return 32;
            default:    return 1;
        endcase
    endfunction

    task automatic model_edge(bit t, bit d);
        int          s = m_st;
        logic [31:0] p_sr = m_sr;
        logic [3:0]  p_ir = m_ir;
        bit          p_busy = m_busy, p_ready = m_ready, p_failed = m_failed;
        bit          done = m_busy && bus_ack;
        bit          start = m_arm && !m_busy;
        int          ln;
        // bus side first; scan writes below take precedence (R11)
        if (done) begin
            m_busy = 0; m_ready = !bus_err; m_failed = bus_err;
            if (!bus_err) begin
                m_addr = m_addr + ((m_bkind == 2'd0) ? 32'd4 : 32'd1);
                if (!m_bwe) m_data = bus_rdata;
            end
        end else if (m_busy) begin
            m_wait++;
        end
        if (start) begin
            if (!m_cmd[3] && m_cmd[1:0] != 2'b11) begin
                m_busy = 1; m_wait = 0; m_bkind = m_cmd[1:0]; m_bwe = !m_cmd[2];
                m_baddr = m_addr; m_bwdata = m_data; m_ready = 0; m_failed = 0;
            end else begin
                m_ready = 1; m_failed = 0;
            end
        end
        m_arm = (s == S_UDR || s == S_UIR) && !t;
        case (s)
            S_TLR: begin
                m_ir = 4'hF; m_cmd = 4'h3; m_addr = '0; m_data = '0;
                m_ready = 0; m_failed = 0;
            end
            S_CIR:  m_sr = 32'd1;
            S_SHIR: m_sr = {28'd0, d, p_sr[3:1]};
            S_UIR:  m_ir = p_sr[3:0];
            S_CDR: begin
                case (p_ir)
                    4'h8:    m_sr = {29'd0, p_ready, p_failed, p_busy};
                    4'h9:    m_sr = {28'd0, m_cmd};
                    4'hA:    m_sr = (done && !bus_err) ? m_addr : m_addr;
                    4'hB:    m_sr = m_data;
                    default: m_sr = '0;
                endcase
            end
            S_SHDR: begin
                ln = len_of(p_ir);
                m_sr = p_sr >> 1;
                m_sr[ln-1] = d;
            end
            S_UDR: begin
                if (p_ir == 4'h9) m_cmd = p_sr[3:0];
                if (p_ir == 4'hA) m_addr = p_sr;
                if (p_ir == 4'hB) m_data = p_sr;
            end
            default: ;
        endcase
        m_st = nxt(s, t);
    endtask

    // one test-clock cycle: drive, compare against the model, clock, advance the model
    task automatic step(bit t, bit d);
        tms = t; tdi = d;
        bus_ack   = m_busy && (force_ack || (m_wait >= ack_lat));
        bus_err   = (m_baddr == ERR_ADDR);
        bus_rdata = m_baddr ^ RD_MASK;
        #1;
        last_tdo = tdo;
        chk("R4 tdo per cycle", {31'd0, tdo},
            {31'd0, ((m_st == S_SHDR) || (m_st == S_SHIR)) ? m_sr[0] : 1'b0});
        chk("R6 bus_req per cycle", {31'd0, bus_req}, {31'd0, m_busy});
        if (m_busy) begin
            chk("R8 bus_addr", bus_addr, m_baddr);
            chk("R8 bus_wdata", bus_wdata, m_bwdata);
            chk("R6 bus_kind", {30'd0, bus_kind}, {30'd0, m_bkind});
            chk("R6 bus_we", {31'd0, bus_we}, {31'd0, m_bwe});
        end
        @(posedge tck);
        if (!finished) model_edge(t, d);
        force_ack = 0;
        @(negedge tck);
    endtask

    task automatic scan_ir(logic [3:0] code, output logic [3:0] o);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i]);
            o[i] = last_tdo;
        end
        step(1, 0);
    endtask

    task automatic scan_dr(int len, logic [31:0] v, output logic [31:0] o);
        o = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, v[i]);
            o[i] = last_tdo;
        end
        step(1, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic wr_reg(logic [3:0] code, logic [31:0] v);
        logic [3:0]  oi;
        logic [31:0] od;
        scan_ir(code, oi);
        scan_dr(len_of(code), v, od);
    endtask

    task automatic rd_reg(logic [3:0] code, output logic [31:0] o);
        logic [3:0] oi;
        scan_ir(code, oi);
        scan_dr(len_of(code), 32'd0, o);
    endtask

    initial begin
        logic [3:0]  oi;
        logic [31:0] o;
        logic [31:0] st_before;
        repeat (3) @(posedge tck);
        @(negedge tck);
        rst_n = 1'b1;
        step(0, 0);

        // R3: capture pattern of the instruction register
        scan_ir(4'h9, oi);
        chk("R3 ir capture", {28'd0, oi}, 32'h1);
        // R2: defaults after reset
        scan_dr(4, 32'h3, o);
        chk("R2 command default", o, 32'h3);
        rd_reg(4'hA, o); chk("R2 address default", o, 32'h0);
        rd_reg(4'hB, o); chk("R2 data default", o, 32'h0);

        // R3: unused code selects a one-bit bypass
        scan_ir(4'h5, oi);
        scan_dr(2, 32'h3, o);
        chk("R3 bypass delay", o, 32'h2);

        // R4/R6/R9: memory write
        wr_reg(4'hA, 32'h0000_0100);
        wr_reg(4'hB, 32'hCAFE_F00D);
        scan_dr(32, 32'hCAFE_F00D, o);
        chk("R4 data readback lsb first", o, 32'hCAFE_F00D);
        wr_reg(4'h9, 32'h0);
        idle(8);
        rd_reg(4'h8, o); chk("R5 status ready after write", o, 32'h4);
        rd_reg(4'hA, o); chk("R9 memory step of 4", o, 32'h0000_0104);

        // R9: core register read captures data, step of 1
        wr_reg(4'hA, 32'h7);
        wr_reg(4'h9, 32'h5);
        idle(8);
        rd_reg(4'hB, o); chk("R9 read data captured", o, 32'h7 ^ RD_MASK);
        rd_reg(4'hA, o); chk("R9 register step of 1", o, 32'h8);

        // R9: auxiliary write
        wr_reg(4'hA, 32'h20);
        wr_reg(4'h9, 32'h2);
        idle(8);
        rd_reg(4'hA, o); chk("R9 aux step of 1", o, 32'h21);

        // R9: bus error
        wr_reg(4'hA, ERR_ADDR);
        wr_reg(4'h9, 32'h4);
        idle(8);
        rd_reg(4'h8, o); chk("R9 failed on error", o, 32'h2);
        rd_reg(4'hA, o); chk("R9 address held on error", o, ERR_ADDR);

        // R7: no-op codes
        wr_reg(4'h9, 32'h3);
        idle(6);
        chk("R7 no request for 0x3", {31'd0, bus_req}, 32'h0);
        rd_reg(4'h8, o); chk("R7 ready after no-op", o, 32'h4);
        wr_reg(4'h9, 32'hC);
        idle(6);
        chk("R7 no request for 0xC", {31'd0, bus_req}, 32'h0);

        // R10/R8: access held in flight
        ack_lat = 100000;
        wr_reg(4'hA, 32'h400);
        wr_reg(4'h9, 32'h4);
        idle(4);
        rd_reg(4'h8, o); chk("R10 stalled only while in flight", o, 32'h1);
        wr_reg(4'hA, 32'h800);
        idle(4);
        chk("R8 start while busy ignored", bus_addr, 32'h400);

        // R11: completion on the address update edge
        ack_lat = 2;
        scan_ir(4'hA, oi);
        scan_dr(32, 32'h2000, o);
        force_ack = 1;
        rd_reg(4'hA, o); chk("R11 scanned address wins", o, 32'h2000);
        rd_reg(4'h8, o); chk("R9 ready after held access", o, 32'h4);
        rd_reg(4'hB, o); chk("R9 held read data", o, 32'h400 ^ RD_MASK);

        // R5: status writes ignored
        scan_ir(4'h8, oi);
        scan_dr(4, 32'hF, o);
        st_before = o;
        rd_reg(4'h8, o); chk("R5 status unchanged by write", o, st_before);
        rd_reg(4'h9, o); chk("R5 command untouched", o, 32'h4);

        // R1: five high mode samples from inside Shift-DR
        scan_ir(4'h9, oi);
        step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 1);
        repeat (5) step(1, 0);
        step(0, 0);
        rd_reg(4'h9, o); chk("R1 reset reached mid-shift", o, 32'h3);
        rd_reg(4'hA, o); chk("R2 address cleared by reset", o, 32'h0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule